// File: doc/BRIEF.md
# Serial Byte Transmitter with Queued Break and Idle Preamble

This block sends bytes on one asynchronous serial line. Software writes a byte into a holding register. At the next bit boundary the byte moves into a shift register and goes out as one frame: a start bit at 0, eight data bits with the least significant bit first, and a stop bit at 1. Every bit lasts one period of the external `bit_tick` strobe. Frames follow each other with no gap as long as the holding register is refilled in time. Two status flags report state: one says the holding register is empty, the other says the line has gone quiet. A single interrupt request combines the two, each through its own enable.

Between items the transmitter can also send two special patterns. An idle preamble is ten bit times at 1. A break character is ten bit times at 0 followed by one stop bit at 1. Software requests them by toggling control inputs. A request is queued and starts at the next item boundary. When the transmitter is switched on, it waits one whole bit period before anything can start.

The controller has six states. `ST_OFF` means disabled. `ST_WARM` is the one-bit warm-up. `ST_READY` means enabled with nothing to send. `ST_DATA`, `ST_PRE` and `ST_BRK` each shift one item. The transitions are:
- OFF→WARM when the enable rises.
- WARM→READY on a tick.
- WARM/READY→OFF when the enable is low.
- READY→DATA/PRE/BRK on a tick when something is queued.
- DATA/PRE/BRK→DATA/PRE/BRK at an item's last tick when something else is queued (back-to-back).
- DATA/PRE/BRK→READY at an item's last tick when nothing is queued and the enable is high.
- DATA/PRE/BRK→OFF at an item's last tick when the enable is low.

Top module: `sertx_top`

## Requirements
- R1: After reset `tx_line` is 1, `dre` is 1, `tc` is 0 and `irq` is 0. The line stays at 1 whenever no frame, preamble or break is being shifted.
- R2: While `tx_en` is 0, nothing is sent. The line stays at 1 and a written byte stays in the holding register (`dre` stays 0).
- R3: After `tx_en` rises, the first `bit_tick` only ends the warm-up. The earliest start bit is driven from the second `bit_tick` onward.
- R4: A data frame is a start bit of 0, then data bits 0 to 7 in that order, then a stop bit of 1. Each bit starts on a `bit_tick` edge and lasts one tick period. A byte that is already waiting follows the previous item with no idle bit.
- R5: `dre` clears on a write and sets on the tick where the held byte moves into the shifter. If a write lands in that same cycle, the old byte is sent, the new byte is kept and `dre` stays 0.
- R6: `tc` sets at the tick that ends an item when nothing is queued behind it. It clears on a write or when a new item starts.
- R7: `irq` = (`txe_ie` AND `dre`) OR (`tc_ie` AND `tc`).
- R8: A low-then-high pulse on `tx_en` while an item is being shifted queues an idle preamble of ten bits at 1. The preamble is sent after the current item and before any waiting byte.
- R9: A falling edge of `brk_req` queues one break character: ten bits at 0, then one stop bit at 1. It is sent after the current item, after a queued preamble, and before a waiting byte.
- R10: Every item boundary at which `brk_req` is 1 starts a break character, so holding the input high sends breaks back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Break request (held or toggled) |
| txe_ie | input | 1 | Interrupt enable for holding-register-empty |
| tc_ie | input | 1 | Interrupt enable for transmission complete |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| tx_line | output | 1 | Serial output, 1 when idle |
| dre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| irq | output | 1 | Combined interrupt request |

## Verification
The risky coincidence is a software write that lands on the same clock edge where the held byte is moved into the shifter. At that edge `dre` is both set by the transfer and cleared by the write.

The bench provokes this by aligning a write strobe with the exact tick that starts a waiting byte. It then judges the result at the line and the flags: the old byte must appear in full, the new byte must follow it with no gap, and `dre` must read 0 right after that edge.

A second overlap is a queued preamble or break meeting a waiting byte at the same boundary. It is judged by the order of the patterns captured on the line.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_OFF,
        ST_WARM,
        ST_READY,
        ST_DATA,
        ST_PRE,
        ST_BRK
    } tx_state_e;

    // Kind of item chosen at a boundary
    typedef enum logic [1:0] {
        ITEM_NONE,
        ITEM_PRE,
        ITEM_BRK,
        ITEM_DATA
    } item_e;

endpackage

// File: rtl/sertx_req.sv
module sertx_req (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic brk_req,
    input  logic busy,
    input  logic off,
    input  logic pre_take,
    input  logic brk_take,
    output logic en_rise,
    output logic pre_pend,
    output logic brk_pend
);

    logic en_q;
    logic brk_q;
    logic brk_fall;

    assign en_rise  = tx_en & ~en_q;
    assign brk_fall = brk_q & ~brk_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            en_q  <= tx_en;
            brk_q <= brk_req;
        end
    end

    // Preamble request: enable re-asserted while an item is shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_pend <= 1'b0;
        end else if (off) begin
            pre_pend <= 1'b0;
        end else if (en_rise && busy) begin
            pre_pend <= 1'b1;
        end else if (pre_take) begin
            pre_pend <= 1'b0;
        end
    end

    // Single break request: falling edge of the break input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_pend <= 1'b0;
        end else if (off) begin
            brk_pend <= 1'b0;
        end else if (brk_fall) begin
            brk_pend <= 1'b1;
        end else if (brk_take) begin
            brk_pend <= 1'b0;
        end
    end

    AST_PRE_CLEARED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> !pre_pend); // R8

    AST_BRK_QUEUED_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_fall && !off) |=> brk_pend); // R9

endmodule

// File: rtl/sertx_flags.sv
module sertx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_data,
    input  logic              item_start,
    input  logic              item_end_quiet,
    input  logic              txe_ie,
    input  logic              tc_ie,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              dre,
    output logic              tc,
    output logic              irq
);

    logic [DATA_W-1:0] hold_q;
    logic              full_q;
    logic              tc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_valid) begin
            hold_q <= wr_data;
        end
    end

    // A write on the transfer edge wins: the new byte stays held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (wr_valid) begin
            full_q <= 1'b1;
        end else if (load_data) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
        end else if (wr_valid) begin
            tc_q <= 1'b0;
        end else if (item_end_quiet) begin
            tc_q <= 1'b1;
        end else if (item_start) begin
            tc_q <= 1'b0;
        end
    end

    always_comb begin
        hold_data = hold_q;
        hold_full = full_q;
        dre       = ~full_q;
        tc        = tc_q;
        irq       = (txe_ie & ~full_q) | (tc_ie & tc_q);
    end

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (!dre && hold_data == $past(wr_data))); // R5

    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (load_data && !wr_valid) |=> dre); // R5

    AST_WRITE_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !tc); // R6

    AST_IRQ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!txe_ie && !tc_ie) |-> !irq); // R7

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PRE_LEN = 10,
    parameter int BRK_LOW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              en_rise,
    input  logic              brk_req,
    input  logic              pre_pend,
    input  logic              brk_pend,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_full,
    output logic              tx_line,
    output logic              busy,
    output logic              off,
    output logic              load_data,
    output logic              pre_take,
    output logic              brk_take,
    output logic              item_start,
    output logic              item_end_quiet
);

    localparam int FRAME_LEN = DATA_W + 2;
    localparam int BRK_LEN   = BRK_LOW + 1;
    localparam int MAX_A     = (FRAME_LEN > PRE_LEN) ? FRAME_LEN : PRE_LEN;
    localparam int SH_W      = (MAX_A > BRK_LEN) ? MAX_A : BRK_LEN;
    localparam int CNT_W     = $clog2(SH_W);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] BRK_LAST   = CNT_W'(BRK_LEN - 1);

    tx_state_e        state_q, state_d;
    item_e            next_item;
    logic [SH_W-1:0]  sh_q;
    logic [SH_W-1:0]  load_vec;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_cnt;
    logic             last_bit;
    logic             boundary;
    logic             launch;

    assign busy     = (state_q == ST_DATA) || (state_q == ST_PRE) || (state_q == ST_BRK);
    assign off      = (state_q == ST_OFF);
    assign last_bit = busy && (cnt_q == '0);
    assign boundary = bit_tick && ((state_q == ST_READY) || last_bit);

    // Queue priority: preamble, then break, then data
    always_comb begin
        if (!tx_en) begin
            next_item = ITEM_NONE;
        end else if (pre_pend) begin
            next_item = ITEM_PRE;
        end else if (brk_pend || brk_req) begin
            next_item = ITEM_BRK;
        end else if (hold_full) begin
            next_item = ITEM_DATA;
        end else begin
            next_item = ITEM_NONE;
        end
    end

    assign launch         = boundary && (next_item != ITEM_NONE);
    assign load_data      = launch && (next_item == ITEM_DATA);
    assign pre_take       = launch && (next_item == ITEM_PRE);
    assign brk_take       = launch && (next_item == ITEM_BRK);
    assign item_start     = launch;
    assign item_end_quiet = bit_tick && last_bit && (next_item == ITEM_NONE);

    // Pattern and bit count for the item about to start
    always_comb begin
        load_vec = '1;
        load_cnt = '0;
        unique case (next_item)
            ITEM_DATA: begin
                load_vec[0]        = 1'b0;
                load_vec[DATA_W:1] = hold_data;
                load_cnt           = FRAME_LAST;
            end
            ITEM_PRE: begin
                load_cnt = PRE_LAST;
            end
            ITEM_BRK: begin
                for (int i = 0; i < BRK_LOW; i++) begin
                    load_vec[i] = 1'b0;
                end
                load_cnt = BRK_LAST;
            end
            ITEM_NONE: begin
                load_cnt = '0;
            end
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_rise) begin
                    state_d = ST_WARM;
                end
            end
            ST_WARM: begin
                if (!tx_en) begin
                    state_d = ST_OFF;
                end else if (bit_tick) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                if (!tx_en) begin
                    state_d = ST_OFF;
                end else if (bit_tick) begin
                    unique case (next_item)
                        ITEM_DATA: state_d = ST_DATA;
                        ITEM_PRE:  state_d = ST_PRE;
                        ITEM_BRK:  state_d = ST_BRK;
                        ITEM_NONE: state_d = ST_READY;
                    endcase
                end
            end
            ST_DATA, ST_PRE, ST_BRK: begin
                if (bit_tick && last_bit) begin
                    unique case (next_item)
                        ITEM_DATA: state_d = ST_DATA;
                        ITEM_PRE:  state_d = ST_PRE;
                        ITEM_BRK:  state_d = ST_BRK;
                        ITEM_NONE: state_d = tx_en ? ST_READY : ST_OFF;
                    endcase
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output shifter and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '1;
            cnt_q <= '0;
        end else if (launch) begin
            sh_q  <= load_vec;
            cnt_q <= load_cnt;
        end else if (busy && bit_tick) begin
            if (last_bit) begin
                sh_q  <= '1;
                cnt_q <= '0;
            end else begin
                sh_q  <= {1'b1, sh_q[SH_W-1:1]};
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (!busy) begin
            sh_q  <= '1;
            cnt_q <= '0;
        end
    end

    assign tx_line = sh_q[0];

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line); // R1

    AST_OFF_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !busy) |=> !busy); // R2

    AST_OFF_EXITS_TO_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> (state_q == ST_OFF || state_q == ST_WARM)); // R3

    AST_WARM_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARM) |=> !busy); // R3

    AST_BIT_HELD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> (state_q == $past(state_q) && $stable(tx_line))); // R4

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DATA_W  = 8,
    parameter int PRE_LEN = DATA_W + 2,
    parameter int BRK_LOW = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              txe_ie,
    input  logic              tc_ie,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_line,
    output logic              dre,
    output logic              tc,
    output logic              irq
);

    logic              en_rise;
    logic              pre_pend;
    logic              brk_pend;
    logic              busy;
    logic              off;
    logic              load_data;
    logic              pre_take;
    logic              brk_take;
    logic              item_start;
    logic              item_end_quiet;
    logic [DATA_W-1:0] hold_data;
    logic              hold_full;

    sertx_req u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .brk_req  (brk_req),
        .busy     (busy),
        .off      (off),
        .pre_take (pre_take),
        .brk_take (brk_take),
        .en_rise  (en_rise),
        .pre_pend (pre_pend),
        .brk_pend (brk_pend)
    );

    sertx_fsm #(
        .DATA_W  (DATA_W),
        .PRE_LEN (PRE_LEN),
        .BRK_LOW (BRK_LOW)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_tick       (bit_tick),
        .tx_en          (tx_en),
        .en_rise        (en_rise),
        .brk_req        (brk_req),
        .pre_pend       (pre_pend),
        .brk_pend       (brk_pend),
        .hold_data      (hold_data),
        .hold_full      (hold_full),
        .tx_line        (tx_line),
        .busy           (busy),
        .off            (off),
        .load_data      (load_data),
        .pre_take       (pre_take),
        .brk_take       (brk_take),
        .item_start     (item_start),
        .item_end_quiet (item_end_quiet)
    );

    sertx_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_valid       (wr_valid),
        .wr_data        (wr_data),
        .load_data      (load_data),
        .item_start     (item_start),
        .item_end_quiet (item_end_quiet),
        .txe_ie         (txe_ie),
        .tc_ie          (tc_ie),
        .hold_data      (hold_data),
        .hold_full      (hold_full),
        .dre            (dre),
        .tc             (tc),
        .irq            (irq)
    );

endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;

    localparam int TDIV = 4;
    localparam int CAPN = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       txe_ie = 1'b0;
    logic       tc_ie = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_line, dre, tc, irq;

    int   checks = 0;
    int   errors = 0;
    int   tick_cnt = 0;
    int   tdiv = 0;
    logic cap [CAPN];

    always #5 clk = ~clk;

    sertx_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .tx_en    (tx_en),
        .brk_req  (brk_req),
        .txe_ie   (txe_ie),
        .tc_ie    (tc_ie),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .tx_line  (tx_line),
        .dre      (dre),
        .tc       (tc),
        .irq      (irq)
    );

    // Record the line value that each consumed tick produced, then set up the next tick
    always @(negedge clk) begin
        if (bit_tick) begin
            if (tick_cnt < CAPN) cap[tick_cnt] = tx_line;
            tick_cnt++;
        end
        tdiv     = (tdiv + 1) % TDIV;
        bit_tick = (tdiv == 0);
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic sync(output int c);
        int c0 = tick_cnt;
        do step(); while (tick_cnt == c0);
        c = tick_cnt;
    endtask

    task automatic wait_tick(int n);
        while (tick_cnt < n) step();
    endtask

    task automatic wr(logic [7:0] v);
        wr_data  = v;
        wr_valid = 1'b1;
        step();
        wr_valid = 1'b0;
    endtask

    task automatic check_frame(int at, logic [7:0] d, string tag);
        logic [9:0] act;
        for (int j = 0; j < 10; j++) act[j] = cap[at + j];
        check(tag, {22'd0, act}, {22'd0, 1'b1, d, 1'b0});
    endtask

    task automatic check_const(int at, int len, logic val, string tag);
        logic [31:0] act = '0;
        logic [31:0] exp = '0;
        for (int j = 0; j < len; j++) begin
            act[j] = cap[at + j];
            exp[j] = val;
        end
        check(tag, act, exp);
    endtask

    task automatic check_break(int at, string tag);
        check_const(at, 10, 1'b0, tag);
        check(tag, {31'd0, cap[at + 10]}, 32'd1);
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c;
        int base;
        repeat (5) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 line", {31'd0, tx_line}, 32'd1);
        check("R1 dre", {31'd0, dre}, 32'd1);
        check("R1 tc", {31'd0, tc}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R7 empty holding register raises irq through txe_ie
        txe_ie = 1'b1; #1;
        check("R7 txe irq", {31'd0, irq}, 32'd1);
        txe_ie = 1'b0; #1;

        // R2 disabled: byte is held, line stays high
        wr(8'h00);
        check("R2 dre held", {31'd0, dre}, 32'd0);
        sync(c);
        wait_tick(c + 6);
        check_const(c, 6, 1'b1, "R2 line idle");
        check("R2 still held", {31'd0, dre}, 32'd0);
        txe_ie = 1'b1; #1;
        check("R7 txe masked by full", {31'd0, irq}, 32'd0);
        txe_ie = 1'b0; tc_ie = 1'b1; #1;
        check("R7 tc low", {31'd0, irq}, 32'd0);
        tc_ie = 1'b0;

        // R3 + R4 sweep of every byte value, back to back
        sync(c);
        base  = c;
        tx_en = 1'b1;
        for (int k = 1; k < 256; k++) begin
            while (dre !== 1'b1) step();
            wr(8'(k));
        end
        wait_tick(base + 2562);
        check("R3 warmup bit", {31'd0, cap[base]}, 32'd1);
        for (int k = 0; k < 256; k++) begin
            check_frame(base + 1 + 10 * k, 8'(k), "R4 frame");
        end
        check("R1 idle after", {31'd0, cap[base + 2561]}, 32'd1);
        check("R6 tc set", {31'd0, tc}, 32'd1);
        check("R5 dre set", {31'd0, dre}, 32'd1);
        tc_ie = 1'b1; #1;
        check("R7 tc irq", {31'd0, irq}, 32'd1);
        tc_ie = 1'b0; #1;
        check("R7 none", {31'd0, irq}, 32'd0);

        // R5 write on the transfer edge
        sync(c);
        wr(8'hA5);
        check("R6 write clears tc", {31'd0, tc}, 32'd0);
        while (dre !== 1'b1) step();
        wr(8'h3C);
        do begin
            @(negedge clk);
            #1;
        end while (!(tick_cnt == c + 10 && bit_tick));
        wr_data  = 8'hC3;
        wr_valid = 1'b1;
        @(posedge clk);
        #2;
        wr_valid = 1'b0;
        check("R5 collision dre", {31'd0, dre}, 32'd0);
        wait_tick(c + 31);
        check_frame(c, 8'hA5, "R5 first");
        check_frame(c + 10, 8'h3C, "R5 old byte");
        check_frame(c + 20, 8'hC3, "R5 new byte");
        check("R6 tc after collision", {31'd0, tc}, 32'd1);

        // R8 enable pulse queues a preamble ahead of waiting data
        sync(c);
        wr(8'h81);
        while (dre !== 1'b1) step();
        wr(8'h5A);
        tx_en = 1'b0;
        step();
        tx_en = 1'b1;
        wait_tick(c + 31);
        check_frame(c, 8'h81, "R8 current");
        check_const(c + 10, 10, 1'b1, "R8 preamble");
        check_frame(c + 20, 8'h5A, "R8 data after");
        check("R8 tc", {31'd0, tc}, 32'd1);

        // R9 break toggle queues one break ahead of waiting data
        sync(c);
        wr(8'hF0);
        step();
        step();
        brk_req = 1'b1;
        step();
        brk_req = 1'b0;
        wr(8'h0F);
        wait_tick(c + 32);
        check_frame(c, 8'hF0, "R9 current");
        check_break(c + 10, "R9 break");
        check_frame(c + 21, 8'h0F, "R9 data after");
        check("R9 tc", {31'd0, tc}, 32'd1);

        // R10 held break repeats; release queues one more
        sync(c);
        brk_req = 1'b1;
        wait_tick(c + 14);
        check("R6 start clears tc", {31'd0, tc}, 32'd0);
        brk_req = 1'b0;
        wait_tick(c + 34);
        check_break(c, "R10 first");
        check_break(c + 11, "R10 second");
        check_break(c + 22, "R10 release");
        check("R10 idle", {31'd0, cap[c + 33]}, 32'd1);
        check("R10 tc", {31'd0, tc}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule